// File: doc/BRIEF.md
# Masked Associative Search Memory

This block is a small, fully parallel content-addressable store. Each of its `DEPTH` slots holds a `WIDTH`-bit word and a valid tag. A search compares one key word against every valid slot in the same clock. A per-bit care mask decides which bit positions take part in the comparison. The per-slot outcomes are captured in a response flag register, and that register then steers the read and purge operations.

Software-free use is the intent. A write needs no address: the block places the word in the lowest-numbered empty slot, and reports when no slot is free. A read returns the lowest-numbered flagged word and indicates whether it was valid. A purge releases every flagged slot back to the empty pool. Operations are chosen with a one-hot code, and each completes in a single clock.

Top module: `assoc_mem`

## Requirements
- R1: While reset is active, and after it is released, every slot is empty. After reset, `flags` is 0, `any_hit` is 0, `multi_hit` is 0, `full` is 0, `rd_data` is 0 and `rd_valid` is 0.
- R2: Opcode 4'b0001 (write) stores `key` into the lowest-index empty slot and marks that slot valid. When every slot is valid, the write changes no state.
- R3: `full` is 1 exactly when all `DEPTH` slots are valid.
- R4: Opcode 4'b0010 (search) loads `flags[i]` with 1 if slot i is valid and, for every bit position where `care` is 1, the stored bit equals the `key` bit. Otherwise `flags[i]` is loaded with 0. Bits where `care` is 0 are ignored. The new flags are visible after that clock edge.
- R5: An empty slot never raises its flag, even when `care` is all zeros.
- R6: `any_hit` is the OR of all flags. `multi_hit` is 1 when two or more flags are set. Both follow the flag register with no extra cycle.
- R7: Opcode 4'b0100 (read) loads `rd_data` with the lowest-index flagged word and sets `rd_valid`. With no flag set, the read loads `rd_data` with 0 and clears `rd_valid`. Other operations leave `rd_data` and `rd_valid` unchanged.
- R8: Opcode 4'b1000 (purge) empties every flagged slot and clears all flags.
- R9: An opcode that is not one-hot, including 0, changes no state. Write and read operations leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op | input | 4 | One-hot operation code |
| key | input | WIDTH | Word to write, or the comparand for a search |
| care | input | WIDTH | Search mask: 1 means the bit takes part in the comparison |
| flags | output | DEPTH | Response flag register, one bit per slot |
| any_hit | output | 1 | At least one flag is set |
| multi_hit | output | 1 | Two or more flags are set |
| full | output | 1 | No empty slot remains |
| rd_data | output | WIDTH | Word returned by the last read |
| rd_valid | output | 1 | The last read found a flagged word |

## Verification
Every operation is applied for exactly one clock edge. Its effects on `flags`, `rd_data`, `rd_valid` and the slot contents are due right after that edge. `any_hit`, `multi_hit` and `full` are derived from registered state with no added delay, so they are due in the same cycle. The bench drives inputs on the falling edge and updates its reference model at the rising edge. It then compares every output on the next falling edge, so every result is checked exactly one cycle after its operation. The internal reset synchronizer adds two cycles after `rst_n` rises, and the bench issues no operation during that window.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int OP_W = 4;
  typedef enum logic [OP_W-1:0] {
    OP_WRITE = 4'b0001,
    OP_MATCH = 4'b0010,
    OP_READ  = 4'b0100,
    OP_PURGE = 4'b1000
  } cam_op_e;
endpackage

// File: rtl/cam_pick.sv
// Lowest-index selector: one-hot grant, encoded index and found flag.
module cam_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    gnt   = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cam_array.sv
// Storage array, valid tags and per-slot masked comparison.
module cam_array #(
  parameter int W  = 16,
  parameter int D  = 8,
  localparam int IW = (D > 1) ? $clog2(D) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [D-1:0]  wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [D-1:0]  drop,
  input  logic [W-1:0]  key,
  input  logic [W-1:0]  care,
  input  logic [IW-1:0] rd_idx,
  output logic [D-1:0]  hit,
  output logic [D-1:0]  valid,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0] mem_q [D];
  logic [D-1:0] valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d = valid_d | wr_sel;
    valid_d = valid_d & ~drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Data storage carries no reset; only the valid tags do.
  always_ff @(posedge clk) begin
    for (int i = 0; i < D; i++) begin
      if (wr_en && wr_sel[i]) mem_q[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < D; g++) begin : g_cmp
    assign hit[g] = valid_q[g] & ~|((mem_q[g] ^ key) & care);
  end

  assign valid   = valid_q;
  assign rd_word = mem_q[rd_idx];

  AST_WRITE_TO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_sel & valid_q) == '0))
    else $error("write aimed at an occupied slot"); // R2
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && drop == '0) |=> ((valid_q & $past(wr_sel)) == $past(wr_sel)))
    else $error("written slot not valid"); // R2
endmodule

// File: rtl/assoc_mem.sv
module assoc_mem #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           op,
  input  logic [WIDTH-1:0]     key,
  input  logic [WIDTH-1:0]     care,
  output logic [DEPTH-1:0]     flags,
  output logic                 any_hit,
  output logic                 multi_hit,
  output logic                 full,
  output logic [WIDTH-1:0]     rd_data,
  output logic                 rd_valid
);
  import cam_pkg::*;

  // Reset: asserted asynchronously, released after two clean edges.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // Operation decode (anything not one-hot is a no-op).
  logic do_wr, do_match, do_rd, do_purge;
  assign do_wr    = (op == OP_WRITE);
  assign do_match = (op == OP_MATCH);
  assign do_rd    = (op == OP_READ);
  assign do_purge = (op == OP_PURGE);

  logic [DEPTH-1:0] hit_vec, valid_vec, free_gnt, rd_gnt, flags_q, flags_d;
  logic [IW-1:0]    free_idx, rd_idx;
  logic             free_found, rd_found;
  logic [WIDTH-1:0] rd_word, rd_data_q, rd_data_d;
  logic             rd_valid_q, rd_valid_d;

  cam_pick #(.N(DEPTH)) u_free_pick (
    .req(~valid_vec), .gnt(free_gnt), .idx(free_idx), .found(free_found)
  );

  cam_pick #(.N(DEPTH)) u_rd_pick (
    .req(flags_q), .gnt(rd_gnt), .idx(rd_idx), .found(rd_found)
  );

  cam_array #(.W(WIDTH), .D(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (do_wr & free_found),
    .wr_sel  (free_gnt),
    .wr_data (key),
    .drop    (do_purge ? flags_q : '0),
    .key     (key),
    .care    (care),
    .rd_idx  (rd_idx),
    .hit     (hit_vec),
    .valid   (valid_vec),
    .rd_word (rd_word)
  );

  // Flag register next state.
  always_comb begin
    flags_d = flags_q;
    if (do_match)      flags_d = hit_vec;
    else if (do_purge) flags_d = '0;
  end

  // Read result next state.
  always_comb begin
    rd_data_d  = rd_data_q;
    rd_valid_d = rd_valid_q;
    if (do_rd) begin
      rd_valid_d = rd_found;
      rd_data_d  = rd_found ? rd_word : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      flags_q    <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      flags_q    <= flags_d;
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  assign flags     = flags_q;
  assign any_hit   = |flags_q;
  assign multi_hit = (flags_q & (flags_q - 1'b1)) != '0;
  assign full      = &valid_vec;
  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;

  AST_FLAGS_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_i_n)
    (flags_q & ~valid_vec) == '0)
    else $error("flag on empty slot"); // R5
  AST_PURGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_i_n)
    do_purge |=> (flags_q == '0))
    else $error("flags survive purge"); // R8
  AST_READ_MISS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (do_rd && !any_hit) |=> (!rd_valid && rd_data == '0))
    else $error("read with no flag returned data"); // R7
  AST_MULTI_ANY: assert property (@(posedge clk) disable iff (!rst_i_n)
    multi_hit |-> any_hit)
    else $error("multi without any"); // R6
  AST_NOOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$onehot(op) |=> ($stable(flags_q) && $stable(valid_vec) && $stable(rd_data_q)))
    else $error("illegal op changed state"); // R9
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (do_wr && full) |=> $stable(valid_vec))
    else $error("write while full changed tags"); // R2
endmodule

// File: tb/tb_assoc_mem.sv
`timescale 1ns/100ps
module tb_assoc_mem;
  localparam int W = 16;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   op;
  logic [W-1:0] key, care;
  logic [D-1:0] flags;
  logic         any_hit, multi_hit, full, rd_valid;
  logic [W-1:0] rd_data;

  assoc_mem #(.WIDTH(W), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .op(op), .key(key), .care(care),
    .flags(flags), .any_hit(any_hit), .multi_hit(multi_hit), .full(full),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Reference model
  logic [W-1:0] m_mem [D];
  logic [D-1:0] m_vld, m_flg;
  logic [W-1:0] m_dout;
  logic         m_rdv;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int count_ones(logic [D-1:0] v);
    int n = 0;
    for (int i = 0; i < D; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic model_match(int i, logic [W-1:0] k, logic [W-1:0] c);
    for (int b = 0; b < W; b++) if (c[b] && (m_mem[i][b] != k[b])) return 1'b0;
    return m_vld[i];
  endfunction

  task automatic model_step(logic [3:0] o, logic [W-1:0] k, logic [W-1:0] c);
    logic done;
    logic [D-1:0] nf;
    case (o)
      4'b0001: begin
        done = 1'b0;
        for (int i = 0; i < D; i++)
          if (!done && !m_vld[i]) begin m_mem[i] = k; m_vld[i] = 1'b1; done = 1'b1; end
      end
      4'b0010: begin
        for (int i = 0; i < D; i++) nf[i] = model_match(i, k, c);
        m_flg = nf;
      end
      4'b0100: begin
        done = 1'b0; m_rdv = 1'b0; m_dout = '0;
        for (int i = 0; i < D; i++)
          if (!done && m_flg[i]) begin m_dout = m_mem[i]; m_rdv = 1'b1; done = 1'b1; end
      end
      4'b1000: begin m_vld = m_vld & ~m_flg; m_flg = '0; end
      default: ;
    endcase
  endtask

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'b0001: return "R2";
      4'b0010: return "R4";
      4'b0100: return "R7";
      4'b1000: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check_all(string tag);
    chk(tag,  "flags",     64'(flags),     64'(m_flg));
    chk(tag,  "rd_data",   64'(rd_data),   64'(m_dout));
    chk(tag,  "rd_valid",  64'(rd_valid),  64'(m_rdv));
    chk("R3", "full",      64'(full),      64'(&m_vld));
    chk("R6", "any_hit",   64'(any_hit),   64'(|m_flg));
    chk("R6", "multi_hit", 64'(multi_hit), 64'(count_ones(m_flg) > 1));
  endtask

  // Drive on the falling edge, model at the rising edge, check on the next falling edge.
  task automatic do_op(logic [3:0] o, logic [W-1:0] k, logic [W-1:0] c);
    op = o; key = k; care = c;
    @(posedge clk);
    model_step(o, k, c);
    @(negedge clk);
    op = 4'b0000;
    check_all(tag_of(o));
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    op = 4'b0000; key = '0; care = '0;
    m_vld = '0; m_flg = '0; m_dout = '0; m_rdv = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // R5: nothing stored, all-don't-care search must not flag
    do_op(4'b0010, 16'h0000, 16'h0000);
    chk("R5", "empty flags", 64'(flags), 64'd0);

    // R2, R3: fill every slot, including duplicates
    for (int i = 0; i < D; i++) do_op(4'b0001, 16'h1200 + 16'(i % 3), 16'h0);
    chk("R3", "full after fill", 64'(full), 64'd1);
    // R2: write while full is ignored; search proves the word never landed
    do_op(4'b0001, 16'hBEEF, 16'h0);
    do_op(4'b0010, 16'hBEEF, 16'hFFFF);
    chk("R2", "ignored write absent", 64'(any_hit), 64'd0);

    // R4: partial mask match
    do_op(4'b0010, 16'h12FF, 16'hFF00);
    chk("R4", "masked all", 64'(flags), 64'hFF);
    do_op(4'b0010, 16'h0001, 16'h000F);
    chk("R4", "exact subset", 64'(flags), 64'h92);
    // R7: lowest flagged word
    do_op(4'b0100, 16'h0, 16'h0);
    chk("R7", "read lowest", 64'(rd_data), 64'h1201);
    // R9: illegal op codes hold state
    do_op(4'b0011, 16'h1200, 16'hFFFF);
    do_op(4'b0000, 16'h1200, 16'hFFFF);
    do_op(4'b1111, 16'h1200, 16'hFFFF);
    chk("R9", "flags held", 64'(flags), 64'h92);
    // R8: purge flagged slots, then R2 refills lowest freed slot
    do_op(4'b1000, 16'h0, 16'h0);
    chk("R8", "not full", 64'(full), 64'd0);
    do_op(4'b0001, 16'h7777, 16'h0);
    do_op(4'b0010, 16'h7777, 16'hFFFF);
    chk("R2", "reuse slot1", 64'(flags), 64'h02);
    // R5: don't-care search flags exactly the valid slots
    do_op(4'b0010, 16'h0, 16'h0);
    chk("R5", "flags==valid", 64'(flags), 64'(m_vld));
    // R7: read miss
    do_op(4'b0010, 16'hDEAD, 16'hFFFF);
    do_op(4'b0100, 16'h0, 16'h0);
    chk("R7", "read miss", 64'(rd_valid), 64'd0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [3:0] o;
      logic [W-1:0] k, c;
      r = $urandom % 100;
      if      (r < 35) o = 4'b0001;
      else if (r < 65) o = 4'b0010;
      else if (r < 80) o = 4'b0100;
      else if (r < 90) o = 4'b1000;
      else             o = 4'($urandom);
      k = {12'hA5C, 4'($urandom % 4)};
      if ($urandom % 8 == 0) k = 16'($urandom);
      c = 16'($urandom);
      do_op(o, k, c);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule